// File: doc/BRIEF.md
# Toroidal Eight-Neighbour Mesh Shifter

This block moves data across a small two-dimensional array of processing elements. One start strobe loads a word into every element, together with a compass direction and a hop count. Every element then passes its word the same number of hops in that direction. Each element keeps the word that arrives from the opposite side. The grid wraps in both axes, so a word that leaves one edge enters again at the opposite edge.

Each element has just four links, one toward each diagonal corner. The links meet at shared crossing switches, one switch per grid cell, with four ports each. A diagonal hop goes straight through a crossing in one clock cycle. A horizontal or vertical hop turns inside the crossing. It needs two cycles: the word is first captured in the crossing's register, then delivered to the neighbour. When the last hop has been applied, a one-cycle done pulse marks the result as valid. The result stays on the outputs until the next operation starts.

Top module: `mesh_shift_top`

## Requirements
- R1: After reset, `busy` and `done` are low and every element word on `dout` is zero.
- R2: The element at row r, column c uses bits [W*(r*COLS+c) +: W] of `din` and `dout`. Rows grow southward and columns grow eastward. Direction codes are 0=N (row-1), 1=NE (row-1, col+1), 2=E (col+1), 3=SE (row+1, col+1), 4=S (row+1), 5=SW (row+1, col-1), 6=W (col-1), 7=NW (row-1, col-1). After one hop, the destination element holds the source element's word.
- R3: Row and column indices wrap modulo ROWS and COLS. A shift of COLS hops east, or ROWS hops north, returns every word to its own element.
- R4: A transfer of h hops gives the same result as h single hops applied in sequence. The hop count and direction are latched when start is accepted.
- R5: For a diagonal direction (odd code) with h ≥ 1, `done` is high in the cycle that follows the h-th rising edge after the edge that accepted start.
- R6: For an orthogonal direction (even code) with h ≥ 1, `done` follows the 2h-th edge after the accepting edge.
- R7: A hop count of zero raises `done` after the first edge. `dout` then equals the loaded `din`.
- R8: Start is accepted only when `busy` is low. `busy` is high from the cycle after acceptance until `done` rises. `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R9: A start raised while `busy` is high is ignored. The running transfer finishes with its original direction, hop count and data.
- R10: While idle and with no start, `dout` holds its value whatever `din`, `dir` and `hops` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| dir | input | 3 | Compass direction code, sampled with start |
| hops | input | HOP_W | Number of hops, sampled with start |
| din | input | ROWS*COLS*W | One word per element, loaded at start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last hop |
| dout | output | ROWS*COLS*W | Word held by each element |

## Verification
Suppose a crossing port or a corner select is wired wrong. The words then land in the wrong elements, and this shows on `dout` in the done cycle of the first transfer that uses that direction. A hop counter or phase bit that slips shows as `done` arriving early or late, which the bench measures to the exact cycle for every transfer. If a start during busy is accepted by mistake, both the result and the latency of that transfer change. If an element register is loaded while idle, `dout` changes during the idle cycles checked after each transfer.

// File: rtl/mesh_shift_pkg.sv
package mesh_shift_pkg;

   // Corner of an element or port of a crossing switch.
   typedef enum logic [1:0] {
      CRN_NW = 2'd0,
      CRN_NE = 2'd1,
      CRN_SE = 2'd2,
      CRN_SW = 2'd3
   } corner_e;

   typedef enum logic [2:0] {
      DIR_N  = 3'd0,
      DIR_NE = 3'd1,
      DIR_E  = 3'd2,
      DIR_SE = 3'd3,
      DIR_S  = 3'd4,
      DIR_SW = 3'd5,
      DIR_W  = 3'd6,
      DIR_NW = 3'd7
   } dir_e;

   // Odd codes are the diagonals.
   function automatic logic dir_is_diag(input logic [2:0] d);
      return d[0];
   endfunction

   // Corner link a source element drives for a direction:
   // N,NE->NE  E,SE->SE  S,SW->SW  W,NW->NW
   function automatic corner_e send_corner(input logic [2:0] d);
      return corner_e'(d[2:1] + 2'd1);
   endfunction

   // Corner link a destination element listens on: the opposite corner
   // for diagonals, the next corner clockwise for turning moves.
   function automatic corner_e recv_corner(input logic [2:0] d);
      return corner_e'(send_corner(d) + (d[0] ? 2'd2 : 2'd1));
   endfunction

endpackage

// File: rtl/mesh_shift_ctrl.sv
module mesh_shift_ctrl
   import mesh_shift_pkg::*;
#(
   parameter int HOP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       dir,
   input  logic [HOP_W-1:0] hops,
   output logic             busy,
   output logic             done,
   output logic             load_in,
   output logic             sw_ld,
   output logic             pe_ld,
   output logic             diag,
   output corner_e          send_c,
   output corner_e          recv_c
);

   typedef enum logic {ST_IDLE, ST_RUN} state_e;

   state_e           state_q, state_d;
   logic [2:0]       dir_q;
   logic [HOP_W-1:0] left_q, left_d;
   logic             phase_q, phase_d;
   logic             done_q, done_d;

   assign load_in = start && (state_q == ST_IDLE);
   assign diag    = dir_is_diag(dir_q);
   assign send_c  = send_corner(dir_q);
   assign recv_c  = recv_corner(dir_q);
   assign busy    = (state_q == ST_RUN);
   assign done    = done_q;

   always_comb begin
      state_d = state_q;
      left_d  = left_q;
      phase_d = phase_q;
      done_d  = 1'b0;
      sw_ld   = 1'b0;
      pe_ld   = 1'b0;
      if (load_in) begin
         state_d = ST_RUN;
         left_d  = hops;
         phase_d = 1'b0;
      end else if (state_q == ST_RUN) begin
         if (left_q == '0) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
         end else if (diag || phase_q) begin
            pe_ld   = 1'b1;
            phase_d = 1'b0;
            left_d  = left_q - 1'b1;
            if (left_q == HOP_W'(1)) begin
               done_d  = 1'b1;
               state_d = ST_IDLE;
            end
         end else begin
            sw_ld   = 1'b1;
            phase_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= '0;
         left_q  <= '0;
         phase_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         phase_q <= phase_d;
         done_q  <= done_d;
         if (load_in) begin
            dir_q <= dir;
         end
      end
   end

endmodule

// File: rtl/mesh_shift_xsw.sv
module mesh_shift_xsw
   import mesh_shift_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] from_nw,
   input  logic [W-1:0] from_ne,
   input  logic [W-1:0] from_se,
   input  logic [W-1:0] from_sw,
   input  corner_e      send_c,
   input  logic         diag,
   input  logic         ld,
   output logic [W-1:0] to_pe
);

   logic [W-1:0] sel_in;
   logic [W-1:0] hold_q;

   // A source sending on corner s reaches this switch at port s+2.
   always_comb begin
      unique case (send_c)
         CRN_SE:  sel_in = from_nw;
         CRN_SW:  sel_in = from_ne;
         CRN_NW:  sel_in = from_se;
         default: sel_in = from_sw;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (ld) begin
         hold_q <= sel_in;
      end
   end

   // Straight through for diagonals, the captured half-move otherwise.
   assign to_pe = diag ? sel_in : hold_q;

endmodule

// File: rtl/mesh_shift_pe.sv
module mesh_shift_pe
   import mesh_shift_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_in,
   input  logic [W-1:0] din,
   input  logic         ld,
   input  corner_e      recv_c,
   input  logic [W-1:0] sw_nw,
   input  logic [W-1:0] sw_ne,
   input  logic [W-1:0] sw_se,
   input  logic [W-1:0] sw_sw,
   output logic [W-1:0] q
);

   logic [W-1:0] arrive;

   always_comb begin
      unique case (recv_c)
         CRN_NW:  arrive = sw_nw;
         CRN_NE:  arrive = sw_ne;
         CRN_SE:  arrive = sw_se;
         default: arrive = sw_sw;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load_in) begin
         q <= din;
      end else if (ld) begin
         q <= arrive;
      end
   end

endmodule

// File: rtl/mesh_shift_top.sv
module mesh_shift_top
   import mesh_shift_pkg::*;
#(
   parameter int ROWS  = 4,
   parameter int COLS  = 8,
   parameter int W     = 8,
   parameter int HOP_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [2:0]             dir,
   input  logic [HOP_W-1:0]       hops,
   input  logic [ROWS*COLS*W-1:0] din,
   output logic                   busy,
   output logic                   done,
   output logic [ROWS*COLS*W-1:0] dout
);

   localparam int NPE = ROWS * COLS;

   if (!(ROWS == COLS || COLS == 2 * ROWS || ROWS == 2 * COLS)) begin : g_bad_shape
      $error("mesh_shift_top: grid must be square or 2:1");
   end
   if (ROWS < 2 || COLS < 2) begin : g_bad_size
      $error("mesh_shift_top: each axis needs at least two elements");
   end
   if (W < 1 || HOP_W < 1) begin : g_bad_width
      $error("mesh_shift_top: W and HOP_W must be positive");
   end

   logic    load_in, sw_ld, pe_ld, diag;
   corner_e send_c, recv_c;

   logic [W-1:0] pe_q  [NPE];
   logic [W-1:0] sw_out[NPE];

   mesh_shift_ctrl #(.HOP_W(HOP_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .dir    (dir),
      .hops   (hops),
      .busy   (busy),
      .done   (done),
      .load_in(load_in),
      .sw_ld  (sw_ld),
      .pe_ld  (pe_ld),
      .diag   (diag),
      .send_c (send_c),
      .recv_c (recv_c)
   );

   // Switch (i,j) sits between rows i,i+1 and columns j,j+1.
   for (genvar i = 0; i < ROWS; i++) begin : g_sw_row
      for (genvar j = 0; j < COLS; j++) begin : g_sw_col
         localparam int IS = (i + 1) % ROWS;
         localparam int JE = (j + 1) % COLS;
         mesh_shift_xsw #(.W(W)) u_xsw (
            .clk    (clk),
            .rst_n  (rst_n),
            .from_nw(pe_q[i  * COLS + j ]),
            .from_ne(pe_q[i  * COLS + JE]),
            .from_se(pe_q[IS * COLS + JE]),
            .from_sw(pe_q[IS * COLS + j ]),
            .send_c (send_c),
            .diag   (diag),
            .ld     (sw_ld),
            .to_pe  (sw_out[i * COLS + j])
         );
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_pe_row
      for (genvar c = 0; c < COLS; c++) begin : g_pe_col
         localparam int RN = (r + ROWS - 1) % ROWS;
         localparam int CW = (c + COLS - 1) % COLS;
         localparam int ID = r * COLS + c;
         mesh_shift_pe #(.W(W)) u_pe (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_in(load_in),
            .din    (din[ID*W +: W]),
            .ld     (pe_ld),
            .recv_c (recv_c),
            .sw_nw  (sw_out[RN * COLS + CW]),
            .sw_ne  (sw_out[RN * COLS + c ]),
            .sw_se  (sw_out[r  * COLS + c ]),
            .sw_sw  (sw_out[r  * COLS + CW]),
            .q      (pe_q[ID])
         );
         assign dout[ID*W +: W] = pe_q[ID];
      end
   end

endmodule

// File: rtl/mesh_shift_chk.sv
module mesh_shift_chk #(
   parameter int ROWS  = 4,
   parameter int COLS  = 8,
   parameter int W     = 8,
   parameter int HOP_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start,
   input logic [2:0]             dir,
   input logic [HOP_W-1:0]       hops,
   input logic                   busy,
   input logic                   done,
   input logic [ROWS*COLS*W-1:0] dout
);

   localparam int LW = HOP_W + 2;

   logic [LW-1:0] exp_len, run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_len <= '0;
         run_cnt <= '0;
      end else if (start && !busy) begin
         run_cnt <= '0;
         if (hops == '0)      exp_len <= LW'(1);
         else if (dir[0])     exp_len <= LW'(hops);
         else                 exp_len <= LW'(hops) << 1;
      end else if (busy) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   // R5, R6, R7: busy span matches the direction class and hop count
   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == exp_len));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(dout));

endmodule

bind mesh_shift_top mesh_shift_chk #(
   .ROWS(ROWS), .COLS(COLS), .W(W), .HOP_W(HOP_W)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .dir  (dir),
   .hops (hops),
   .busy (busy),
   .done (done),
   .dout (dout)
);

// File: tb/mesh_shift_top_test.sv
module mesh_shift_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS  = 4;
   localparam int COLS  = 8;
   localparam int W     = 8;
   localparam int HOP_W = 4;
   localparam int N     = ROWS * COLS;
   localparam int VW    = N * W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [2:0]       dir = '0;
   logic [HOP_W-1:0] hops = '0;
   logic [VW-1:0]    din = '0;
   logic             busy, done;
   logic [VW-1:0]    dout;

   int checks = 0;
   int fails  = 0;

   mesh_shift_top #(.ROWS(ROWS), .COLS(COLS), .W(W), .HOP_W(HOP_W)) uut (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .dir  (dir),
      .hops (hops),
      .din  (din),
      .busy (busy),
      .done (done),
      .dout (dout)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [VW-1:0] ref_shift(input logic [VW-1:0] src,
                                               input int d, input int h);
      logic [VW-1:0] res;
      int dr, dc;
      case (d)
         0: begin dr = -1; dc =  0; end
         1: begin dr = -1; dc =  1; end
         2: begin dr =  0; dc =  1; end
         3: begin dr =  1; dc =  1; end
         4: begin dr =  1; dc =  0; end
         5: begin dr =  1; dc = -1; end
         6: begin dr =  0; dc = -1; end
         default: begin dr = -1; dc = -1; end
      endcase
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            int sr, sc;
            sr = (((r - h * dr) % ROWS) + ROWS) % ROWS;
            sc = (((c - h * dc) % COLS) + COLS) % COLS;
            res[(r*COLS+c)*W +: W] = src[(sr*COLS+sc)*W +: W];
         end
      end
      return res;
   endfunction

   function automatic int ref_len(input int d, input int h);
      if (h == 0) return 1;
      return (d % 2 == 1) ? h : 2 * h;
   endfunction

   function automatic logic [VW-1:0] rand_vec();
      logic [VW-1:0] v;
      for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk_int(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_vec(input string req, input string what,
                          input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One transfer; optionally poke a conflicting start while busy (R9).
   task automatic run_op(input int d, input int h, input logic [VW-1:0] data,
                         input string req, input bit poke);
      int n;
      logic [VW-1:0] exp_v, held;
      @(negedge clk);
      start = 1'b1; dir = 3'(d); hops = HOP_W'(h); din = data;
      @(negedge clk);
      n = 0;
      chk_int("R8", "busy after accept", int'(busy), 1);
      if (poke) begin
         start = 1'b1; dir = 3'(d ^ 3); hops = HOP_W'(h + 3); din = ~data;
      end else begin
         start = 1'b0; din = rand_vec(); dir = 3'($urandom); hops = HOP_W'($urandom);
      end
      while (!done && n < 100) begin
         @(negedge clk);
         start = 1'b0;
         n++;
      end
      exp_v = ref_shift(data, d, h);
      chk_int(d % 2 == 1 ? (h == 0 ? "R7" : "R5") : (h == 0 ? "R7" : "R6"),
              $sformatf("latency dir=%0d hops=%0d", d, h), n, ref_len(d, h));
      chk_vec(poke ? "R9" : req, $sformatf("result dir=%0d hops=%0d", d, h), dout, exp_v);
      chk_int("R8", "busy low with done", int'(busy), 0);
      held = dout;
      din = rand_vec(); dir = 3'($urandom); hops = HOP_W'($urandom);
      @(negedge clk);
      chk_int("R8", "done one cycle", int'(done), 0);
      @(negedge clk);
      chk_vec("R10", "idle hold", dout, held);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [VW-1:0] v;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk_int("R1", "busy after reset", int'(busy), 0);
      chk_int("R1", "done after reset", int'(done), 0);
      chk_vec("R1", "dout after reset", dout, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: each single-hop direction
      for (int d = 0; d < 8; d++) run_op(d, 1, rand_vec(), "R2", 1'b0);
      // R7: zero hops returns input
      v = rand_vec();
      run_op(3, 0, v, "R7", 1'b0);
      chk_vec("R7", "zero hop identity", dout, v);
      run_op(4, 0, rand_vec(), "R7", 1'b0);
      // R3: full wrap in each axis is identity
      v = rand_vec();
      run_op(2, COLS, v, "R3", 1'b0);
      chk_vec("R3", "east full wrap", dout, v);
      v = rand_vec();
      run_op(0, ROWS, v, "R3", 1'b0);
      chk_vec("R3", "north full wrap", dout, v);
      run_op(5, ROWS + 1, rand_vec(), "R3", 1'b0);
      // R4: multi-hop, including two hops northwest and maximum count
      run_op(7, 2, rand_vec(), "R4", 1'b0);
      run_op(6, 15, rand_vec(), "R4", 1'b0);
      run_op(1, 15, rand_vec(), "R4", 1'b0);
      // R9: start while busy is ignored
      run_op(2, 3, rand_vec(), "R9", 1'b1);
      run_op(3, 0, rand_vec(), "R9", 1'b1);
      run_op(4, 1, rand_vec(), "R9", 1'b1);
      // Random mix
      for (int k = 0; k < 40; k++) begin
         run_op(int'($urandom % 8), int'($urandom % 10), rand_vec(), "R4", 1'($urandom % 4 == 0));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule